// File: doc/BRIEF.md
# Bit-Addressable I/O Register Bank

This block holds a bank of 8-bit I/O registers that a processor core reaches in two ways. A byte port reads any address without waiting and writes a whole register in one clock. A single-bit port sets, clears or tests one bit of a register in the low part of the address space. A test returns whether the skip condition holds, so the core can decide whether to skip its next instruction.

One register holds status flags. Hardware sets these flags from event inputs, and software clears a flag by writing a one to its position. Single-bit set and clear change only the named bit. A bit operation on this register therefore never clears a flag that is still pending.

Some addresses are reserved and have no storage. The bank ignores byte writes to them, and they read as zero. One register has only some of its bits implemented, and the missing bits read as zero. A bit operation always completes in two clock cycles: one busy cycle, then one done cycle. A bit operation aimed above the bit-addressable range raises an error pulse and does nothing else.

Top module: `bitio_bank`

## Requirements
- R1: After reset every register reads 0x00, and `bop_busy`, `bop_done` and `bop_err` are low.
- R2: A byte write stores `io_wdata` at `io_addr`, and `io_rdata` shows it combinationally from the next cycle. At address 0x18 bits 7:6 are not implemented and always read zero, whether written by byte or by a bit operation.
- R3: The reserved addresses are 0x00–0x02, 0x09–0x0C, 0x19–0x1B, 0x36 and 0x3C. They read as zero, and byte writes to them have no effect.
- R4: At address 0x08, bits 3:0 are flags and bits 7:4 are plain storage. A byte write clears each flag whose written bit is one and keeps each flag whose written bit is zero. Bits 7:4 take the written value.
- R5: A one on `evt_set[i]` for i in 3:0 sets flag i of address 0x08 at the next edge, and `evt_set[7:4]` are ignored. When an event and a byte-write clear hit the same flag in the same cycle, the flag ends up set.
- R6: A bit set (`bop_kind`=0) makes the named bit one, and a bit clear (`bop_kind`=1) makes it zero. Every other bit of that register keeps its value, including pending flags at 0x08.
- R7: A request accepted while idle drives `bop_busy` high for exactly the next cycle and `bop_done` high for exactly the cycle after that. The new register value is visible on `io_rdata` in the done cycle.
- R8: In the done cycle of a test, `bop_skip` is high when the bit is one (`bop_kind`=2) or when the bit is zero (`bop_kind`=3). For set and clear it is low. A test leaves the register unchanged.
- R9: A bit-operation request to an address of 0x20 or above gives a one-cycle `bop_err` pulse in the next cycle. It produces no busy or done cycle and changes no register.
- R10: A bit operation on a reserved address inside 0x00–0x1F runs the normal busy/done sequence but changes nothing. A test there sees the bit as zero.
- R11: A `bop_req` raised while `bop_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | Byte port address, used for both read and write |
| io_we | input | 1 | Byte write strobe |
| io_wdata | input | 8 | Byte write data |
| io_rdata | output | 8 | Read data for `io_addr` |
| evt_set | input | 8 | Hardware flag-set events for address 0x08 |
| bop_req | input | 1 | Bit-operation request |
| bop_kind | input | 2 | 0 set, 1 clear, 2 skip-if-one, 3 skip-if-zero |
| bop_addr | input | 6 | Bit-operation address |
| bop_bit | input | 3 | Bit position |
| bop_busy | output | 1 | Bit operation in progress |
| bop_done | output | 1 | Bit operation completes this cycle |
| bop_skip | output | 1 | Skip decision, valid with `bop_done` |
| bop_err | output | 1 | Bit-operation address out of range |

## Verification
The flag register is given several patterns, and each one separates a correct design from a specific wrong one:
- Byte writes with mixed ones and zeros separate write-one-to-clear from plain storage.
- An event in the same cycle as a clearing write shows whether the set takes priority.
- Bit clears of a plain bit and of one flag, made while other flags are pending, show whether a bit operation disturbs its neighbours.

Set, clear and both test kinds are also run against an ordinary register, a partly implemented register, a reserved address and an out-of-range address. A request held during the busy cycle shows whether the sequencer can be re-entered.

// File: rtl/bitio_pkg.sv
`timescale 1ns/1ps
package bitio_pkg;
  typedef enum logic [1:0] {
    BOP_SET  = 2'b00,
    BOP_CLR  = 2'b01,
    BOP_TST1 = 2'b10,
    BOP_TST0 = 2'b11
  } bop_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } bop_state_e;
endpackage

// File: rtl/bitio_decode.sv
`timescale 1ns/1ps
module bitio_decode #(
  parameter int ADDR_W = 6,
  parameter int BITOP_LIMIT = 32,
  parameter logic [(2**ADDR_W)-1:0] RSVD_MAP = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              rsvd,
  output logic              bit_ok
);
  localparam logic [ADDR_W:0] LIM = BITOP_LIMIT[ADDR_W:0];

  assign rsvd   = RSVD_MAP[addr];
  assign bit_ok = ({1'b0, addr} < LIM);
endmodule

// File: rtl/bitio_regfile.sv
`timescale 1ns/1ps
module bitio_regfile #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [(2**ADDR_W)-1:0] RSVD_MAP = '0,
  parameter int FLAG_ADDR = 8,
  parameter logic [DATA_W-1:0] FLAG_MASK = '0,
  parameter int PART_ADDR = 24,
  parameter logic [DATA_W-1:0] PART_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bw_en,
  input  logic [ADDR_W-1:0] bw_addr,
  input  logic [DATA_W-1:0] bw_data,
  input  logic [DATA_W-1:0] evt_set,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  localparam int NUM_ADDR = 2**ADDR_W;

  logic [DATA_W-1:0] q [NUM_ADDR];

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_ent
    if (RSVD_MAP[a]) begin : g_rsvd
      assign q[a] = '0;
    end else begin : g_reg
      localparam logic [DATA_W-1:0] FM = (a == FLAG_ADDR) ? FLAG_MASK : '0;
      localparam logic [DATA_W-1:0] IM = (a == PART_ADDR) ? PART_MASK : '1;
      localparam logic [ADDR_W-1:0] MY = ADDR_W'(a);
      logic [DATA_W-1:0] r_q, r_d;
      logic              r_en;

      always_comb begin
        r_d  = r_q;
        r_en = 1'b0;
        if (wr_en && (wr_addr == MY)) begin
          r_d  = (r_q & ~wr_data & FM) | (wr_data & ~FM);
          r_en = 1'b1;
        end
        if (bw_en && (bw_addr == MY)) begin
          r_d  = bw_data;
          r_en = 1'b1;
        end
        // hardware set applied last: set beats a same-cycle clear
        if ((evt_set & FM) != '0) begin
          r_d  = r_d | (evt_set & FM);
          r_en = 1'b1;
        end
        r_d = r_d & IM;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    r_q <= '0;
        else if (r_en) r_q <= r_d;
      end

      assign q[a] = r_q;
    end
  end

  assign ra_data = q[ra_addr];
  assign rb_data = q[rb_addr];
endmodule

// File: rtl/bitio_bitop.sv
`timescale 1ns/1ps
module bitio_bitop
  import bitio_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int BITOP_LIMIT = 32,
  parameter logic [(2**ADDR_W)-1:0] RSVD_MAP = '0,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BIT_W-1:0]  bitsel,
  input  logic [DATA_W-1:0] cur_data,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              bw_en,
  output logic [DATA_W-1:0] bw_data,
  output logic              busy,
  output logic              done,
  output logic              skip,
  output logic              err
);
  bop_state_e        st_q, st_d;
  bop_kind_e         k_q;
  logic [ADDR_W-1:0] a_q;
  logic [BIT_W-1:0]  b_q;
  logic              rsvd_q;
  logic              cap, done_d, skip_d, err_d;
  logic              done_q, skip_q, err_q;
  logic              in_rsvd, in_ok, bit_now;

  bitio_decode #(
    .ADDR_W(ADDR_W), .BITOP_LIMIT(BITOP_LIMIT), .RSVD_MAP(RSVD_MAP)
  ) u_dec (
    .addr(addr), .rsvd(in_rsvd), .bit_ok(in_ok)
  );

  always_comb begin
    st_d    = st_q;
    cap     = 1'b0;
    done_d  = 1'b0;
    skip_d  = 1'b0;
    err_d   = 1'b0;
    bit_now = cur_data[b_q];
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          if (in_ok) begin
            st_d = ST_BUSY;
            cap  = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        case (k_q)
          BOP_TST1: skip_d = bit_now;
          BOP_TST0: skip_d = !bit_now;
          default:  skip_d = 1'b0;
        endcase
      end
    endcase
  end

  always_comb begin
    bw_data       = cur_data;
    bw_data[b_q]  = (k_q == BOP_SET);
    bw_en         = (st_q == ST_BUSY) && !rsvd_q &&
                    ((k_q == BOP_SET) || (k_q == BOP_CLR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      skip_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      skip_q <= skip_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= BOP_SET;
      a_q    <= '0;
      b_q    <= '0;
      rsvd_q <= 1'b0;
    end else if (cap) begin
      k_q    <= bop_kind_e'(kind);
      a_q    <= addr;
      b_q    <= bitsel;
      rsvd_q <= in_rsvd;
    end
  end

  assign tgt_addr = a_q;
  assign busy     = (st_q == ST_BUSY);
  assign done     = done_q;
  assign skip     = skip_q;
  assign err      = err_q;
endmodule

// File: rtl/bitio_bank.sv
`timescale 1ns/1ps
module bitio_bank #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int BITOP_LIMIT = 32,
  parameter logic [(2**ADDR_W)-1:0] RSVD_MAP = 64'h1040_0000_0E00_1E07,
  parameter int FLAG_ADDR = 8,
  parameter logic [DATA_W-1:0] FLAG_MASK = 8'h0F,
  parameter int PART_ADDR = 24,
  parameter logic [DATA_W-1:0] PART_MASK = 8'h3F,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_we,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] evt_set,
  input  logic              bop_req,
  input  logic [1:0]        bop_kind,
  input  logic [ADDR_W-1:0] bop_addr,
  input  logic [BIT_W-1:0]  bop_bit,
  output logic              bop_busy,
  output logic              bop_done,
  output logic              bop_skip,
  output logic              bop_err
);
  logic [1:0]        rs_q;
  logic              rst_n_i;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data, bw_data;
  logic              bw_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  bitio_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSVD_MAP(RSVD_MAP),
    .FLAG_ADDR(FLAG_ADDR), .FLAG_MASK(FLAG_MASK),
    .PART_ADDR(PART_ADDR), .PART_MASK(PART_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_i),
    .wr_en(io_we), .wr_addr(io_addr), .wr_data(io_wdata),
    .bw_en(bw_en), .bw_addr(tgt_addr), .bw_data(bw_data),
    .evt_set(evt_set),
    .ra_addr(io_addr), .ra_data(io_rdata),
    .rb_addr(tgt_addr), .rb_data(tgt_data)
  );

  bitio_bitop #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BITOP_LIMIT(BITOP_LIMIT),
    .RSVD_MAP(RSVD_MAP)
  ) u_bop (
    .clk(clk), .rst_n(rst_n_i),
    .req(bop_req), .kind(bop_kind), .addr(bop_addr), .bitsel(bop_bit),
    .cur_data(tgt_data), .tgt_addr(tgt_addr),
    .bw_en(bw_en), .bw_data(bw_data),
    .busy(bop_busy), .done(bop_done), .skip(bop_skip), .err(bop_err)
  );
endmodule

// File: rtl/bitio_bank_chk.sv
`timescale 1ns/1ps
module bitio_bank_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [(2**ADDR_W)-1:0] RSVD_MAP = '0,
  parameter int PART_ADDR = 24,
  parameter logic [DATA_W-1:0] PART_MASK = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_rdata,
  input logic              bop_req,
  input logic              bop_busy,
  input logic              bop_done,
  input logic              bop_err
);
  localparam logic [ADDR_W-1:0] PART_A = ADDR_W'(PART_ADDR);

  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bop_busy |=> !bop_busy); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bop_busy |=> bop_done); // R7
  AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bop_done |-> $past(bop_busy)); // R7
  AST_ERR_FROM_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bop_err |-> $past(bop_req && !bop_busy)); // R9
  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bop_busy, bop_done, bop_err})); // R9
  AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    RSVD_MAP[io_addr] |-> (io_rdata == '0)); // R3
  AST_PART_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == PART_A) |-> ((io_rdata & ~PART_MASK) == '0)); // R2
endmodule

bind bitio_bank bitio_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSVD_MAP(RSVD_MAP),
  .PART_ADDR(PART_ADDR), .PART_MASK(PART_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rdata(io_rdata),
  .bop_req(bop_req), .bop_busy(bop_busy), .bop_done(bop_done),
  .bop_err(bop_err)
);

// File: tb/test_bitio_bank.sv
`timescale 1ns/1ps
module test_bitio_bank;
  localparam logic [63:0] RSVD = 64'h1040_0000_0E00_1E07;

  logic       clk, rst_n;
  logic [5:0] io_addr;
  logic       io_we;
  logic [7:0] io_wdata, io_rdata, evt_set;
  logic       bop_req;
  logic [1:0] bop_kind;
  logic [5:0] bop_addr;
  logic [2:0] bop_bit;
  logic       bop_busy, bop_done, bop_skip, bop_err;

  bitio_bank i_bitio_bank (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .evt_set(evt_set),
    .bop_req(bop_req), .bop_kind(bop_kind), .bop_addr(bop_addr),
    .bop_bit(bop_bit), .bop_busy(bop_busy), .bop_done(bop_done),
    .bop_skip(bop_skip), .bop_err(bop_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    string      req;
    int         chan;   // 0 rdata, 1 skip, 2 {busy,done,err}
    logic [7:0] exp;
  } item_t;

  item_t      sbq[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         fin = 0;
  logic [7:0] mem [64];

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t      it;
      logic [7:0] act;
      it = sbq.pop_front();
      case (it.chan)
        0:       act = io_rdata;
        1:       act = {7'b0, bop_skip};
        default: act = {5'b0, bop_busy, bop_done, bop_err};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: chan %0d actual %02h expected %02h", it.req, it.chan, act, it.exp);
      end
    end
  end

  function automatic logic [7:0] fm(int a);
    return (a == 8) ? 8'h0F : 8'h00;
  endfunction
  function automatic logic [7:0] im(int a);
    return (a == 24) ? 8'h3F : 8'hFF;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(string r, int ch, logic [7:0] e);
    item_t it;
    it.req = r; it.chan = ch; it.exp = e;
    sbq.push_back(it);
  endtask

  task automatic rd(string r, int a);
    io_addr = 6'(a);
    push(r, 0, mem[a]);
    tick();
  endtask

  task automatic wr(int a, logic [7:0] d, logic [7:0] ev);
    io_addr = 6'(a); io_we = 1'b1; io_wdata = d; evt_set = ev;
    tick();
    io_we = 1'b0; evt_set = 8'h00;
    if (!RSVD[a]) mem[a] = ((mem[a] & ~d & fm(a)) | (d & ~fm(a))) & im(a);
    mem[8] = mem[8] | (ev & fm(8));
  endtask

  task automatic bop(string r, logic [1:0] k, int a, int b);
    logic       bitv, sk;
    bop_req = 1'b1; bop_kind = k; bop_addr = 6'(a); bop_bit = 3'(b);
    tick();
    bop_req = 1'b0;
    if (a >= 32) begin
      push(r, 2, 8'h01);
      tick();
      push(r, 2, 8'h00);
    end else begin
      push(r, 2, 8'h04);
      tick();
      bitv = mem[a][b];
      sk = (k == 2'd2) ? bitv : (k == 2'd3) ? !bitv : 1'b0;
      if (!RSVD[a] && (k == 2'd0 || k == 2'd1)) begin
        mem[a][b] = (k == 2'd0);
        mem[a] = mem[a] & im(a);
      end
      push(r, 2, 8'h02);
      push(r, 1, {7'b0, sk});
      io_addr = 6'(a);
      push(r, 0, mem[a]);
    end
    tick();
  endtask

  initial begin
    #(8 * 60000);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog R7: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    rst_n = 1'b0; io_addr = '0; io_we = 1'b0; io_wdata = '0; evt_set = '0;
    bop_req = 1'b0; bop_kind = '0; bop_addr = '0; bop_bit = '0;
    tick(); tick();
    push("R1 idle", 2, 8'h00);
    rd("R1 reset flags", 8);
    rd("R1 reset top", 63);
    rst_n = 1'b1;
    tick(); tick(); tick();
    push("R1 idle after release", 2, 8'h00);
    rd("R1 after release", 5);

    // R2 byte path and partial register
    wr(63, 8'hC3, 8'h00); rd("R2 write 0x3F", 63);
    wr(5, 8'h96, 8'h00);  rd("R2 write 0x05", 5);
    wr(24, 8'hFF, 8'h00); rd("R2 partial bits", 24);
    wr(40, 8'h5A, 8'h00); rd("R2 write 0x28", 40);

    // R3 reserved addresses
    wr(0, 8'hFF, 8'h00);  rd("R3 reserved 0x00", 0);
    wr(60, 8'h77, 8'h00); rd("R3 reserved 0x3C", 60);
    wr(26, 8'h11, 8'h00); rd("R3 reserved 0x1A", 26);

    // R5 events, R4 write-one-to-clear
    wr(63, 8'hC3, 8'hFB); rd("R5 event sets flags", 8);
    wr(8, 8'hA2, 8'h00);  rd("R4 w1c mixed", 8);
    wr(8, 8'h00, 8'h00);  rd("R4 zero keeps flags", 8);
    wr(8, 8'h01, 8'h05);  rd("R5 set wins", 8);
    wr(8, 8'hA0, 8'h00);  rd("R4 plain bits", 8);

    // R6 single-bit set/clear, R7 timing checked inside bop
    bop("R6 clr plain bit", 2'd1, 8, 7);
    bop("R6 set plain bit", 2'd0, 8, 6);
    bop("R6 clr one flag", 2'd1, 8, 2);
    bop("R6 set ordinary", 2'd0, 5, 0);
    bop("R7 clr zero bit", 2'd1, 31, 3);

    // R8 tests
    bop("R8 tst1 set bit", 2'd2, 8, 3);
    bop("R8 tst1 clear bit", 2'd2, 8, 2);
    bop("R8 tst0 clear bit", 2'd3, 8, 2);
    bop("R8 tst0 set bit", 2'd3, 5, 0);

    // R9 out of range
    bop("R9 set 0x28", 2'd0, 40, 0);
    rd("R9 0x28 unchanged", 40);
    bop("R9 tst 0x3F", 2'd2, 63, 0);

    // R10 reserved inside range, R2 via bit op
    bop("R10 set reserved", 2'd0, 1, 4);
    bop("R10 tst reserved", 2'd3, 1, 4);
    bop("R2 set missing bit", 2'd0, 24, 7);

    // R11 request during busy is ignored
    bop_req = 1'b1; bop_kind = 2'd0; bop_addr = 6'd5; bop_bit = 3'd3;
    tick();
    push("R11 busy", 2, 8'h04);
    bop_kind = 2'd1; bop_bit = 3'd0;
    tick();
    bop_req = 1'b0;
    mem[5][3] = 1'b1;
    push("R11 done", 2, 8'h02);
    tick();
    push("R11 no second op", 2, 8'h00);
    rd("R11 only first applied", 5);

    tick();
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule